// File: doc/BRIEF.md
# Write-Protect Controller for a Serial EEPROM Slave

This block sits beside the byte engine of a two-wire serial EEPROM slave and decides, byte by byte, whether the slave acknowledges and whether a finished transfer may start a nonvolatile write cycle. The byte engine reports bus events to it: START, STOP, each completed byte with its role, and the SCL rise that samples bit D0 of the first data byte. The write-cycle timer reports when a cycle ends. The block answers one cycle after each byte with an acknowledge decision. On STOP it issues a commit pulse that starts the write cycle.

Protection comes from three sources. A soft flag guards the lower half of the array (word addresses with the top bit clear) and can be cleared again. A permanent flag guards the same half and can never be cleared. The hardware write-protect pin guards the whole array while it is high. The two flags are changed by protect commands. These commands are sent under the device-type code 0110 instead of the memory code 1010. They are acknowledged only while the pin is low, and they take effect at the end of their own write cycle. Both flags are modelled as registers.

If the protect pin rises at any time from the D0 sampling edge of the first data byte until the write cycle ends, the pending or running write is aborted at once. The block then returns to idle without waiting out the cycle. A sticky flag records that the target data is undefined.

Top module: `wp_guard`

## Requirements
- R1: After reset, soft_prot, perm_prot, busy, data_undef, commit_go, abort_pulse and ack_vld are all 0.
- R2: A slave byte (byte_kind 0, bits [7:4] type, [3:1] select, [0] read) is acknowledged when the type is 1010 and the select equals strap, for reads and writes alike, even while wp_pin is high. Any other type, or a select that does not match strap, is not acknowledged.
- R3: A type-0110 write with select 001 (set command) is acknowledged while wp_pin is low. Its word byte (kind 1) and data byte (kind 2) are acknowledged whatever their values. A STOP then raises commit_go and busy, and wcyc_done sets soft_prot.
- R4: A type-0110 write with select 011 (clear command), carried out the same way, clears soft_prot and leaves perm_prot unchanged.
- R5: A type-0110 write whose select equals strap while a0_hv is 1 (permanent command) sets perm_prot at wcyc_done. perm_prot never returns to 0, and once it is set every protect command's slave byte is not acknowledged.
- R6: While soft_prot or perm_prot is 1, a data byte aimed at a word address below 80h is not acknowledged. A data byte aimed at 80h or above is still acknowledged.
- R7: While wp_pin is high, memory data bytes and protect-command slave bytes are not acknowledged.
- R8: A type-0110 slave byte with the read bit set is not acknowledged.
- R9: While busy, every byte is not acknowledged. After wcyc_done, a matching slave byte is acknowledged again.
- R10: wp_pin high from the cycle after a D0 edge until the write cycle ends produces abort_pulse for one cycle. It also drops busy, sets the sticky data_undef and leaves both protect flags unchanged.
- R11: wp_pin pulses that end before the D0 edge have no effect on cancellation: the write is acknowledged and commits normally.
- R12: A STOP with no acknowledged data byte (and, for protect commands, no acknowledged word and data byte) raises neither commit_go nor busy.
- R13: After a slave byte that was not acknowledged, word and data bytes up to the next START are not acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_evt | input | 1 | START seen on the bus (one-cycle pulse) |
| stop_evt | input | 1 | STOP seen; acts as the write-commit request |
| byte_evt | input | 1 | A byte has been received (one-cycle pulse) |
| byte_kind | input | 2 | Role of the byte: 0 slave, 1 word address, 2 data |
| byte_val | input | 8 | Byte value |
| strap | input | 3 | Device-address strap pins |
| a0_hv | input | 1 | High-voltage level detected on the lowest strap pin |
| wp_pin | input | 1 | Hardware write-protect pin |
| d0_edge | input | 1 | SCL rise sampling D0 of a data byte |
| wcyc_done | input | 1 | Write-cycle timer expired |
| ack_vld | output | 1 | Acknowledge decision valid (cycle after byte_evt) |
| ack | output | 1 | 1 = acknowledge the byte |
| commit_go | output | 1 | Start of a write cycle (one-cycle pulse) |
| commit_mem | output | 1 | With commit_go: 1 = memory write, 0 = protect command |
| busy | output | 1 | Write cycle in progress |
| abort_pulse | output | 1 | Write cancelled by wp_pin |
| data_undef | output | 1 | Sticky: an aborted write left data undefined |
| soft_prot | output | 1 | Clearable lower-half protection |
| perm_prot | output | 1 | Permanent lower-half protection |

## Verification
The case that needs the most care is when the protect pin and the write machinery act in the same cycle. A rising wp_pin can meet a running write cycle while wcyc_done is pending, or meet the STOP that would commit. The bench raises wp_pin during busy and then checks abort_pulse, busy, data_undef and the flag that the aborted protect command would have changed. A second collision is a byte event arriving while a cycle is busy. There the acknowledge policy has to give way to the busy state, which the bench shows by polling with slave bytes before and after wcyc_done. The bench also pulses wp_pin before the D0 edge to confirm that it does not cancel anything.

// File: rtl/wp_guard_pkg.sv
package wp_guard_pkg;

    typedef enum logic [1:0] {
        BK_SLAVE = 2'd0,
        BK_WORD  = 2'd1,
        BK_DATA  = 2'd2
    } byte_kind_e;

    typedef enum logic [2:0] {
        CMD_NONE,
        CMD_MEM_WR,
        CMD_MEM_RD,
        CMD_SET,
        CMD_CLR,
        CMD_PERM
    } cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_MEM,
        ST_PROT,
        ST_IGNORE,
        ST_BUSY
    } state_e;

    typedef struct packed {
        logic [3:0] dtype;
        logic [2:0] dsel;
        logic       rd;
    } slave_byte_t;

    localparam logic [3:0] MEM_TYPE  = 4'b1010;
    localparam logic [3:0] PROT_TYPE = 4'b0110;
    localparam logic [2:0] SEL_SET   = 3'b001;
    localparam logic [2:0] SEL_CLR   = 3'b011;

    function automatic cmd_e decode_slave(slave_byte_t sb, logic [2:0] strap, logic hv);
        cmd_e c;
        c = CMD_NONE;
        if (sb.dtype == MEM_TYPE && sb.dsel == strap) begin
            c = sb.rd ? CMD_MEM_RD : CMD_MEM_WR;
        end else if (sb.dtype == PROT_TYPE && !sb.rd) begin
            if (hv && sb.dsel == strap)   c = CMD_PERM;
            else if (sb.dsel == SEL_SET)  c = CMD_SET;
            else if (sb.dsel == SEL_CLR)  c = CMD_CLR;
        end
        return c;
    endfunction

    function automatic logic is_prot_cmd(cmd_e c);
        return (c == CMD_SET) || (c == CMD_CLR) || (c == CMD_PERM);
    endfunction

endpackage

// File: rtl/wp_cmd_decode.sv
module wp_cmd_decode
    import wp_guard_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic [BYTE_W-1:0] byte_val,
    input  logic [2:0]        strap,
    input  logic              a0_hv,
    output cmd_e              cmd
);
    slave_byte_t sb;

    always_comb begin
        sb  = slave_byte_t'(byte_val[7:0]);
        cmd = decode_slave(sb, strap, a0_hv);
    end
endmodule

// File: rtl/wp_ack_policy.sv
module wp_ack_policy
    import wp_guard_pkg::*;
(
    input  state_e     state,
    input  byte_kind_e kind,
    input  cmd_e       cmd,
    input  logic       wp_pin,
    input  logic       lower_half,
    input  logic       soft_prot,
    input  logic       perm_prot,
    output logic       ack_ok
);
    logic lower_locked;

    always_comb begin
        lower_locked = lower_half && (soft_prot || perm_prot);
        ack_ok = 1'b0;
        unique case (kind)
            BK_SLAVE: begin
                if (state == ST_IDLE) begin
                    if (cmd == CMD_MEM_WR || cmd == CMD_MEM_RD)
                        ack_ok = 1'b1;
                    else if (is_prot_cmd(cmd))
                        ack_ok = !wp_pin && !perm_prot;
                end
            end
            BK_WORD: begin
                if (state == ST_MEM)       ack_ok = 1'b1;
                else if (state == ST_PROT) ack_ok = !wp_pin;
            end
            BK_DATA: begin
                if (state == ST_MEM)       ack_ok = !wp_pin && !lower_locked;
                else if (state == ST_PROT) ack_ok = !wp_pin;
            end
            default: ack_ok = 1'b0;
        endcase
    end
endmodule

// File: rtl/wp_flag_store.sv
module wp_flag_store (
    input  logic clk,
    input  logic rst,
    input  logic apply_set,
    input  logic apply_clr,
    input  logic apply_perm,
    output logic soft_prot,
    output logic perm_prot
);
    always_ff @(posedge clk) begin
        if (rst) begin
            soft_prot <= 1'b0;
            perm_prot <= 1'b0;
        end else begin
            if (apply_set)      soft_prot <= 1'b1;
            else if (apply_clr) soft_prot <= 1'b0;
            if (apply_perm)     perm_prot <= 1'b1;
        end
    end

    // R5: permanent protection never drops
    p_perm_sticky_r5: assert property (@(posedge clk) disable iff (rst)
        perm_prot |=> perm_prot);

    // R4: soft flag moves only on a committed set or clear
    p_soft_only_on_apply_r4: assert property (@(posedge clk) disable iff (rst)
        (soft_prot != $past(soft_prot)) |-> ($past(apply_set) || $past(apply_clr)));
endmodule

// File: rtl/wp_cycle_ctrl.sv
module wp_cycle_ctrl
    import wp_guard_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_evt,
    input  logic              stop_evt,
    input  logic              byte_evt,
    input  byte_kind_e        kind,
    input  logic [ADDR_W-1:0] word_addr,
    input  cmd_e              cmd,
    input  logic              ack_ok,
    input  logic              wp_pin,
    input  logic              d0_edge,
    input  logic              wcyc_done,
    output state_e            state,
    output logic              lower_half,
    output logic              commit_go,
    output logic              commit_mem,
    output logic              abort_pulse,
    output logic              data_undef,
    output logic              apply_set,
    output logic              apply_clr,
    output logic              apply_perm
);
    localparam int CNT_W = 2;

    cmd_e              cmd_q;
    logic [ADDR_W-1:0] addr_q;
    logic [CNT_W-1:0]  prot_cnt;
    logic              pending;
    logic              armed;
    logic              cancel;

    assign lower_half = !addr_q[ADDR_W-1];
    assign cancel     = armed && wp_pin;

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_IDLE;
            cmd_q       <= CMD_NONE;
            addr_q      <= '0;
            prot_cnt    <= '0;
            pending     <= 1'b0;
            armed       <= 1'b0;
            commit_go   <= 1'b0;
            commit_mem  <= 1'b0;
            abort_pulse <= 1'b0;
            data_undef  <= 1'b0;
            apply_set   <= 1'b0;
            apply_clr   <= 1'b0;
            apply_perm  <= 1'b0;
        end else begin
            commit_go   <= 1'b0;
            abort_pulse <= 1'b0;
            apply_set   <= 1'b0;
            apply_clr   <= 1'b0;
            apply_perm  <= 1'b0;
            if (state == ST_BUSY) begin
                if (cancel) begin
                    abort_pulse <= 1'b1;
                    data_undef  <= 1'b1;
                    armed       <= 1'b0;
                    state       <= ST_IDLE;
                end else if (wcyc_done) begin
                    apply_set  <= (cmd_q == CMD_SET);
                    apply_clr  <= (cmd_q == CMD_CLR);
                    apply_perm <= (cmd_q == CMD_PERM);
                    armed      <= 1'b0;
                    state      <= ST_IDLE;
                end
            end else if (cancel) begin
                abort_pulse <= 1'b1;
                data_undef  <= 1'b1;
                armed       <= 1'b0;
                pending     <= 1'b0;
                state       <= ST_IGNORE;
            end else if (start_evt) begin
                state    <= ST_IDLE;
                pending  <= 1'b0;
                armed    <= 1'b0;
                prot_cnt <= '0;
            end else if (stop_evt) begin
                pending <= 1'b0;
                if (pending) begin
                    state      <= ST_BUSY;
                    commit_go  <= 1'b1;
                    commit_mem <= (cmd_q == CMD_MEM_WR);
                end else begin
                    state <= ST_IDLE;
                    armed <= 1'b0;
                end
            end else begin
                if (byte_evt) begin
                    if (!ack_ok) begin
                        state <= ST_IGNORE;
                    end else begin
                        unique case (kind)
                            BK_SLAVE: begin
                                cmd_q    <= cmd;
                                prot_cnt <= '0;
                                if (cmd == CMD_MEM_WR)   state <= ST_MEM;
                                else if (is_prot_cmd(cmd)) state <= ST_PROT;
                                else                     state <= ST_IGNORE;
                            end
                            BK_WORD: begin
                                addr_q <= word_addr;
                                if (state == ST_PROT) prot_cnt <= prot_cnt + 1'b1;
                            end
                            BK_DATA: begin
                                if (state == ST_MEM) pending <= 1'b1;
                                else if (prot_cnt != '0) pending <= 1'b1;
                            end
                            default: state <= ST_IGNORE;
                        endcase
                    end
                end
                if (d0_edge && (state == ST_MEM || state == ST_PROT))
                    armed <= 1'b1;
            end
        end
    end

    // R10: protect pin inside the cancellation window aborts next cycle
    p_cancel_aborts_r10: assert property (@(posedge clk) disable iff (rst)
        cancel |=> (abort_pulse && data_undef && state != ST_BUSY));

    // R12: a commit only follows a STOP
    p_commit_needs_stop_r12: assert property (@(posedge clk) disable iff (rst)
        commit_go |-> $past(stop_evt));

    // R10: undefined-data flag is sticky
    p_undef_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        data_undef |=> data_undef);
endmodule

// File: rtl/wp_guard.sv
module wp_guard
    import wp_guard_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_evt,
    input  logic              stop_evt,
    input  logic              byte_evt,
    input  logic [1:0]        byte_kind,
    input  logic [BYTE_W-1:0] byte_val,
    input  logic [2:0]        strap,
    input  logic              a0_hv,
    input  logic              wp_pin,
    input  logic              d0_edge,
    input  logic              wcyc_done,
    output logic              ack_vld,
    output logic              ack,
    output logic              commit_go,
    output logic              commit_mem,
    output logic              busy,
    output logic              abort_pulse,
    output logic              data_undef,
    output logic              soft_prot,
    output logic              perm_prot
);
    byte_kind_e kind;
    cmd_e       cmd;
    state_e     state;
    logic       ack_ok;
    logic       lower_half;
    logic       apply_set, apply_clr, apply_perm;

    assign kind = byte_kind_e'(byte_kind);
    assign busy = (state == ST_BUSY);

    wp_cmd_decode #(.BYTE_W(BYTE_W)) u_dec (
        .byte_val (byte_val),
        .strap    (strap),
        .a0_hv    (a0_hv),
        .cmd      (cmd)
    );

    wp_ack_policy u_pol (
        .state      (state),
        .kind       (kind),
        .cmd        (cmd),
        .wp_pin     (wp_pin),
        .lower_half (lower_half),
        .soft_prot  (soft_prot),
        .perm_prot  (perm_prot),
        .ack_ok     (ack_ok)
    );

    wp_cycle_ctrl #(.ADDR_W(ADDR_W)) u_ctl (
        .clk         (clk),
        .rst         (rst),
        .start_evt   (start_evt),
        .stop_evt    (stop_evt),
        .byte_evt    (byte_evt),
        .kind        (kind),
        .word_addr   (byte_val[ADDR_W-1:0]),
        .cmd         (cmd),
        .ack_ok      (ack_ok),
        .wp_pin      (wp_pin),
        .d0_edge     (d0_edge),
        .wcyc_done   (wcyc_done),
        .state       (state),
        .lower_half  (lower_half),
        .commit_go   (commit_go),
        .commit_mem  (commit_mem),
        .abort_pulse (abort_pulse),
        .data_undef  (data_undef),
        .apply_set   (apply_set),
        .apply_clr   (apply_clr),
        .apply_perm  (apply_perm)
    );

    wp_flag_store u_flags (
        .clk        (clk),
        .rst        (rst),
        .apply_set  (apply_set),
        .apply_clr  (apply_clr),
        .apply_perm (apply_perm),
        .soft_prot  (soft_prot),
        .perm_prot  (perm_prot)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ack_vld <= 1'b0;
            ack     <= 1'b0;
        end else begin
            ack_vld <= byte_evt;
            ack     <= byte_evt && ack_ok;
        end
    end

    // R9: no acknowledge while a write cycle runs
    p_no_ack_busy_r9: assert property (@(posedge clk) disable iff (rst)
        (byte_evt && busy) |=> (ack_vld && !ack));

    // R7: data bytes are refused while the protect pin is high
    p_wp_blocks_data_r7: assert property (@(posedge clk) disable iff (rst)
        (byte_evt && kind == BK_DATA && wp_pin) |=> !ack);

    // R5: with permanent protection, protect commands are refused
    p_perm_refuses_cmd_r5: assert property (@(posedge clk) disable iff (rst)
        (byte_evt && kind == BK_SLAVE && perm_prot && byte_val[7:4] == PROT_TYPE) |=> !ack);
endmodule

// File: tb/wp_guard_tb.sv
module wp_guard_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_evt = 0, stop_evt = 0, byte_evt = 0;
    logic [1:0] byte_kind = 0;
    logic [7:0] byte_val = 0;
    logic [2:0] strap = 3'b101;
    logic       a0_hv = 0, wp_pin = 0, d0_edge = 0, wcyc_done = 0;
    logic       ack_vld, ack, commit_go, commit_mem, busy, abort_pulse, data_undef;
    logic       soft_prot, perm_prot;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    wp_guard u_dut (
        .clk(clk), .rst(rst), .start_evt(start_evt), .stop_evt(stop_evt),
        .byte_evt(byte_evt), .byte_kind(byte_kind), .byte_val(byte_val),
        .strap(strap), .a0_hv(a0_hv), .wp_pin(wp_pin), .d0_edge(d0_edge),
        .wcyc_done(wcyc_done), .ack_vld(ack_vld), .ack(ack),
        .commit_go(commit_go), .commit_mem(commit_mem), .busy(busy),
        .abort_pulse(abort_pulse), .data_undef(data_undef),
        .soft_prot(soft_prot), .perm_prot(perm_prot)
    );

    // vector: {slave byte, strap, hv, wp, expected ack}
    localparam int NV = 12;
    localparam logic [13:0] VEC [NV] = '{
        {8'b1010_101_0, 3'b101, 1'b0, 1'b0, 1'b1},
        {8'b1010_100_0, 3'b101, 1'b0, 1'b0, 1'b0},
        {8'b1010_101_1, 3'b101, 1'b0, 1'b0, 1'b1},
        {8'b0110_001_0, 3'b101, 1'b0, 1'b0, 1'b1},
        {8'b0110_011_0, 3'b101, 1'b0, 1'b0, 1'b1},
        {8'b0110_001_1, 3'b101, 1'b0, 1'b0, 1'b0},
        {8'b0110_010_0, 3'b101, 1'b0, 1'b0, 1'b0},
        {8'b0110_001_0, 3'b101, 1'b0, 1'b1, 1'b0},
        {8'b0110_101_0, 3'b101, 1'b1, 1'b0, 1'b1},
        {8'b0110_101_0, 3'b101, 1'b0, 1'b0, 1'b0},
        {8'b1100_101_0, 3'b101, 1'b0, 1'b0, 1'b0},
        {8'b1010_011_0, 3'b011, 1'b0, 1'b1, 1'b1}
    };

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic do_start();
        start_evt = 1; tick(); start_evt = 0;
    endtask

    task automatic send(logic [1:0] k, logic [7:0] v, logic exp, string tag);
        byte_kind = k; byte_val = v; byte_evt = 1;
        tick();
        byte_evt = 0;
        chk(tag, {6'd0, ack_vld, ack}, {6'd0, 1'b1, exp});
    endtask

    task automatic do_stop(logic exp, string tag);
        stop_evt = 1; tick(); stop_evt = 0;
        chk(tag, {6'd0, commit_go, busy}, {6'd0, exp, exp});
    endtask

    task automatic do_done(string tag);
        wcyc_done = 1; tick(); wcyc_done = 0;
        tick();
        chk(tag, {7'd0, busy}, 8'd0);
    endtask

    task automatic pulse_d0();
        d0_edge = 1; tick(); d0_edge = 0;
    endtask

    task automatic mem_write(logic [7:0] a, logic exp_data, string tag);
        do_start();
        send(2'd0, {4'b1010, strap, 1'b0}, 1'b1, tag);
        send(2'd1, a, 1'b1, tag);
        pulse_d0();
        send(2'd2, 8'h5A, exp_data, tag);
    endtask

    task automatic prot_cmd(logic [2:0] sel, string tag);
        do_start();
        send(2'd0, {4'b0110, sel, 1'b0}, 1'b1, tag);
        send(2'd1, 8'h33, 1'b1, tag);
        pulse_d0();
        send(2'd2, 8'hC4, 1'b1, tag);
        do_stop(1'b1, tag);
        chk(tag, {7'd0, commit_mem}, 8'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst = 0;
        tick();
        // R1 reset state
        chk("R1 flags", {4'd0, soft_prot, perm_prot, busy, data_undef}, 8'd0);
        chk("R1 pulses", {5'd0, commit_go, abort_pulse, ack_vld}, 8'd0);

        // R2 R7 R8: slave byte decode table
        for (int i = 0; i < NV; i++) begin
            strap  = VEC[i][5:3];
            a0_hv  = VEC[i][2];
            wp_pin = VEC[i][1];
            do_start();
            send(2'd0, VEC[i][13:6], VEC[i][0], $sformatf("R2/R7/R8 vec%0d", i));
            do_stop(1'b0, "R12 stop without data");
        end
        strap = 3'b101; a0_hv = 0; wp_pin = 0;

        // R13: bytes after a refused slave byte are refused
        do_start();
        send(2'd0, 8'b1010_000_0, 1'b0, "R13 slave");
        send(2'd1, 8'h10, 1'b0, "R13 word");
        send(2'd2, 8'h11, 1'b0, "R13 data");
        do_stop(1'b0, "R13 no commit");

        // unprotected write, then polling R9
        mem_write(8'h10, 1'b1, "R6 unprot low");
        do_stop(1'b1, "R9 commit");
        chk("R9 commit_mem", {7'd0, commit_mem}, 8'd1);
        send(2'd0, 8'b1010_101_0, 1'b0, "R9 poll busy");
        do_done("R9 done");
        send(2'd0, 8'b1010_101_0, 1'b1, "R9 poll ready");
        do_stop(1'b0, "R9 poll stop");

        // R3 set
        prot_cmd(3'b001, "R3 set");
        do_done("R3 done");
        chk("R3 soft", {6'd0, soft_prot, perm_prot}, 8'd2);

        // R6 lower refused, upper accepted
        mem_write(8'h20, 1'b0, "R6 low locked");
        do_stop(1'b0, "R6/R12 no commit");
        mem_write(8'h90, 1'b1, "R6 high ok");
        do_stop(1'b1, "R6 commit");
        do_done("R6 done");

        // R7 pin high refuses upper data
        wp_pin = 1;
        do_start();
        send(2'd0, 8'b1010_101_0, 1'b1, "R7 slave");
        send(2'd1, 8'h90, 1'b1, "R7 word");
        send(2'd2, 8'h01, 1'b0, "R7 data");
        do_stop(1'b0, "R7 no commit");
        wp_pin = 0;

        // R11 pin pulse before D0 ignored
        do_start();
        send(2'd0, 8'b1010_101_0, 1'b1, "R11 slave");
        wp_pin = 1;
        send(2'd1, 8'hA0, 1'b1, "R11 word");
        wp_pin = 0;
        tick();
        pulse_d0();
        send(2'd2, 8'h77, 1'b1, "R11 data");
        do_stop(1'b1, "R11 commit");
        do_done("R11 done");
        chk("R11 undef", {7'd0, data_undef}, 8'd0);

        // R4 clear
        prot_cmd(3'b011, "R4 clr");
        do_done("R4 done");
        chk("R4 flags", {6'd0, soft_prot, perm_prot}, 8'd0);
        mem_write(8'h20, 1'b1, "R4 low writable");
        do_stop(1'b1, "R4 commit");
        do_done("R4 done2");

        // R10 abort of memory write during cycle
        mem_write(8'hA0, 1'b1, "R10 mem");
        do_stop(1'b1, "R10 commit");
        wp_pin = 1;
        tick();
        chk("R10 abort", {5'd0, abort_pulse, busy, data_undef}, 8'b101);
        wp_pin = 0;
        tick();
        chk("R10 pulse one cycle", {7'd0, abort_pulse}, 8'd0);

        // R10 abort of set command leaves flags
        prot_cmd(3'b001, "R10 set");
        wp_pin = 1;
        tick();
        chk("R10 abort cmd", {6'd0, abort_pulse, busy}, 8'b10);
        wp_pin = 0;
        tick();
        chk("R10 flags kept", {6'd0, soft_prot, perm_prot}, 8'd0);

        // R5 permanent
        a0_hv = 1;
        prot_cmd(3'b101, "R5 perm");
        a0_hv = 0;
        do_done("R5 done");
        chk("R5 perm", {6'd0, soft_prot, perm_prot}, 8'd1);
        do_start();
        send(2'd0, 8'b0110_011_0, 1'b0, "R5 clr refused");
        do_stop(1'b0, "R5 no commit");
        mem_write(8'h05, 1'b0, "R5/R6 low locked");
        do_stop(1'b0, "R5 no commit2");
        mem_write(8'hF0, 1'b1, "R5 high ok");
        do_stop(1'b1, "R5 commit");
        do_done("R5 done2");
        chk("R5 perm kept", {7'd0, perm_prot}, 8'd1);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule